// File: doc/BRIEF.md
# Shared-Bus Register Datapath with Store Sequencer

This block is a bus-organised datapath. Every register can be routed onto two operand buses, A and B, by a 3-bit source code. Both buses feed one ALU followed by one shifter. The shifter output is staged in a RESULT register, and a separate 3-bit destination code copies RESULT into one register. Each register transfer therefore takes two cycles: an evaluate step that captures RESULT, then a put step that writes it back. A read-only register holding the value one sits on the source map, so any register can be incremented by adding it through the ALU.

While the built-in sequencer is idle, the surrounding controller drives the micro-operation fields directly (source A, source B, function, shift, RESULT load, destination). Source code 3 places the external data input on a bus. This is how values from memory or from outside enter the registers. A one-cycle `start` pulse launches the store-from-S routine, which runs nine internal steps. First it copies PC to MAR, then increments PC, then overwrites MAR with S, then copies the accumulator to MBR. Finally it raises the memory strobe and write strobe together for one cycle, with MAR as the address and MBR as the write data. A `done` pulse follows, and the block returns to idle.

The sequencer states, in order, are ST_IDLE, ST_PC2MAR_EVAL, ST_PC2MAR_PUT, ST_INC_EVAL, ST_INC_PUT, ST_S2MAR_EVAL, ST_S2MAR_PUT, ST_A2MBR_EVAL, ST_A2MBR_PUT, ST_MEM_WRITE and ST_FINISH. Each state advances unconditionally to the next one. The only exceptions are ST_IDLE, which stays put until `start` is high, and ST_FINISH, which returns to ST_IDLE.

Top module: `busdp_core`

## Requirements
- R1: After reset, PC, accumulator, S, MAR, MBR and RESULT are zero, and `mem_ma`, `mem_wr`, `busy` and `done` are low.
- R2: Both operand buses decode the source code the same way: 0 gives zero, 1 gives the constant one, 2 gives PC, 3 gives `ext_data`, 4 gives the accumulator, 5 gives S, 6 gives MAR and 7 gives MBR.
- R3: Function code 0 passes bus A unchanged. Function code 5 yields A plus B modulo 2^16. Every other function code yields zero.
- R4: Shift code 1 shifts left by one and fills with zero. Shift code 2 shifts right by one and fills with zero. Shift codes 0 and 3 leave the value unchanged.
- R5: RESULT takes the shifter output at an edge where the load field is high and holds its value otherwise. When a load and a destination write occur in the same cycle, the destination receives the RESULT value from before that edge.
- R6: Destination code 2 writes PC, 4 writes the accumulator, 5 writes S, 6 writes MAR and 7 writes MBR. Codes 0, 1 and 3 write nothing, and the constant register always reads as one.
- R7: A `start` pulse while idle runs the store routine. Afterwards MAR equals S, MBR equals the accumulator, PC has advanced by one modulo 2^16, the accumulator and S are unchanged, and RESULT holds the accumulator value.
- R8: `mem_ma` and `mem_wr` rise together for exactly one cycle, the ninth cycle after the edge that accepts `start`. In that cycle `mem_addr` equals S and `mem_wdata` equals the accumulator.
- R9: `busy` is high from the cycle after `start` is accepted through the cycle in which `done` is high. `done` is high for exactly the one cycle after the write cycle, and `busy` is low in the following cycle.
- R10: While `busy` is high, the external micro-operation fields, `ext_data` and `start` have no effect on any register.
- R11: `mem_addr` always shows MAR and `mem_wdata` always shows MBR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch the store-from-S routine (accepted only when idle) |
| ext_data | input | 16 | Value placed on a bus by source code 3 |
| op_src_a | input | 3 | External source code for bus A |
| op_src_b | input | 3 | External source code for bus B |
| op_fn | input | 3 | External ALU function code |
| op_sh | input | 2 | External shift code |
| op_res_ld | input | 1 | External RESULT load enable |
| op_dest | input | 3 | External destination code |
| result_q | output | 16 | Current RESULT register |
| mem_addr | output | 16 | Memory address (MAR) |
| mem_wdata | output | 16 | Memory write data (MBR) |
| mem_ma | output | 1 | Memory access strobe |
| mem_wr | output | 1 | Memory write strobe |
| busy | output | 1 | Sequencer is running |
| done | output | 1 | One-cycle completion pulse |

## Verification
Two functions can land on the same clock edge: RESULT capturing a new value, and the destination write-back of the value RESULT held before that edge. The bench provokes this by issuing one micro-operation that carries both a load of `ext_data` and a destination code. It then judges the result by reading the destination register back and comparing it with the older RESULT value, while `result_q` already shows the new one. The store routine is also driven with conflicting external fields and a repeated `start` throughout its busy window. The bench judges that overlap by the exact cycle of the write strobe and by the register contents read back afterwards.

// File: rtl/busdp_pkg.sv
package busdp_pkg;

    typedef logic [2:0] sel_t;
    typedef logic [2:0] fn_t;
    typedef logic [1:0] sh_t;

    localparam sel_t SEL_ZERO = 3'd0;
    localparam sel_t SEL_ONE  = 3'd1;
    localparam sel_t SEL_PC   = 3'd2;
    localparam sel_t SEL_EXT  = 3'd3;
    localparam sel_t SEL_ACC  = 3'd4;
    localparam sel_t SEL_S    = 3'd5;
    localparam sel_t SEL_MAR  = 3'd6;
    localparam sel_t SEL_MBR  = 3'd7;

    localparam int   NUM_SLOTS = 8;
    // slots that a destination code may overwrite
    localparam logic [NUM_SLOTS-1:0] WRITABLE_MASK = 8'b1111_0100;

    localparam fn_t FN_PASS = 3'd0;
    localparam fn_t FN_ADD  = 3'd5;

    localparam sh_t SH_NONE  = 2'd0;
    localparam sh_t SH_LEFT  = 2'd1;
    localparam sh_t SH_RIGHT = 2'd2;

    typedef struct packed {
        sel_t src_a;
        sel_t src_b;
        fn_t  fn;
        sh_t  sh;
        logic res_ld;
        sel_t dest;
    } uop_t;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PC2MAR_EVAL,
        ST_PC2MAR_PUT,
        ST_INC_EVAL,
        ST_INC_PUT,
        ST_S2MAR_EVAL,
        ST_S2MAR_PUT,
        ST_A2MBR_EVAL,
        ST_A2MBR_PUT,
        ST_MEM_WRITE,
        ST_FINISH
    } seq_state_e;

endpackage

// File: rtl/busdp_regfile.sv
module busdp_regfile
    import busdp_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  sel_t          dest,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] ext_data,
    input  sel_t          src_a,
    input  sel_t          src_b,
    output logic [DW-1:0] bus_a,
    output logic [DW-1:0] bus_b,
    output logic [DW-1:0] mar_q,
    output logic [DW-1:0] mbr_q
);

    localparam logic [DW-1:0] CONST_ONE = {{(DW-1){1'b0}}, 1'b1};

    logic [DW-1:0] slot [NUM_SLOTS];

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        if (WRITABLE_MASK[g]) begin : g_reg
            logic [DW-1:0] q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    q <= '0;
                end else if (dest == 3'(g)) begin
                    q <= wdata;
                end
            end
            assign slot[g] = q;
        end else if (3'(g) == SEL_ONE) begin : g_one
            assign slot[g] = CONST_ONE;
        end else if (3'(g) == SEL_EXT) begin : g_ext
            assign slot[g] = ext_data;
        end else begin : g_zero
            assign slot[g] = '0;
        end
    end

    assign bus_a = slot[src_a];
    assign bus_b = slot[src_b];
    assign mar_q = slot[SEL_MAR];
    assign mbr_q = slot[SEL_MBR];

endmodule

// File: rtl/busdp_alu_shift.sv
module busdp_alu_shift
    import busdp_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic [DW-1:0] opa,
    input  logic [DW-1:0] opb,
    input  fn_t           fn,
    input  sh_t           sh,
    output logic [DW-1:0] y
);

    logic [DW-1:0] alu_y;

    always_comb begin
        unique case (fn)
            FN_PASS: alu_y = opa;
            FN_ADD:  alu_y = opa + opb;
            default: alu_y = '0;
        endcase
    end

    always_comb begin
        unique case (sh)
            SH_LEFT:  y = {alu_y[DW-2:0], 1'b0};
            SH_RIGHT: y = {1'b0, alu_y[DW-1:1]};
            default:  y = alu_y;
        endcase
    end

endmodule

// File: rtl/busdp_store_seq.sv
module busdp_store_seq
    import busdp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output uop_t uop,
    output logic busy,
    output logic done,
    output logic mem_ma,
    output logic mem_wr
);

    seq_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:        if (start) state_d = ST_PC2MAR_EVAL;
            ST_PC2MAR_EVAL: state_d = ST_PC2MAR_PUT;
            ST_PC2MAR_PUT:  state_d = ST_INC_EVAL;
            ST_INC_EVAL:    state_d = ST_INC_PUT;
            ST_INC_PUT:     state_d = ST_S2MAR_EVAL;
            ST_S2MAR_EVAL:  state_d = ST_S2MAR_PUT;
            ST_S2MAR_PUT:   state_d = ST_A2MBR_EVAL;
            ST_A2MBR_EVAL:  state_d = ST_A2MBR_PUT;
            ST_A2MBR_PUT:   state_d = ST_MEM_WRITE;
            ST_MEM_WRITE:   state_d = ST_FINISH;
            ST_FINISH:      state_d = ST_IDLE;
            default:        state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        uop    = '0;
        busy   = (state_q != ST_IDLE);
        done   = 1'b0;
        mem_ma = 1'b0;
        mem_wr = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_PC2MAR_EVAL: begin
                uop.src_a  = SEL_PC;
                uop.fn     = FN_PASS;
                uop.sh     = SH_NONE;
                uop.res_ld = 1'b1;
            end
            ST_PC2MAR_PUT:  uop.dest = SEL_MAR;
            ST_INC_EVAL: begin
                uop.src_a  = SEL_PC;
                uop.src_b  = SEL_ONE;
                uop.fn     = FN_ADD;
                uop.sh     = SH_NONE;
                uop.res_ld = 1'b1;
            end
            ST_INC_PUT:     uop.dest = SEL_PC;
            ST_S2MAR_EVAL: begin
                uop.src_a  = SEL_S;
                uop.fn     = FN_PASS;
                uop.res_ld = 1'b1;
            end
            ST_S2MAR_PUT:   uop.dest = SEL_MAR;
            ST_A2MBR_EVAL: begin
                uop.src_a  = SEL_ACC;
                uop.fn     = FN_PASS;
                uop.res_ld = 1'b1;
            end
            ST_A2MBR_PUT:   uop.dest = SEL_MBR;
            ST_MEM_WRITE: begin
                mem_ma = 1'b1;
                mem_wr = 1'b1;
            end
            ST_FINISH:      done = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/busdp_core.sv
module busdp_core
    import busdp_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [DW-1:0] ext_data,
    input  logic [2:0]    op_src_a,
    input  logic [2:0]    op_src_b,
    input  logic [2:0]    op_fn,
    input  logic [1:0]    op_sh,
    input  logic          op_res_ld,
    input  logic [2:0]    op_dest,
    output logic [DW-1:0] result_q,
    output logic [DW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic          mem_ma,
    output logic          mem_wr,
    output logic          busy,
    output logic          done
);

    uop_t          ext_uop, seq_uop, uop_sel;
    logic          res_ld_sel;
    logic [DW-1:0] bus_a, bus_b, shift_y;

    assign ext_uop = '{src_a: op_src_a, src_b: op_src_b, fn: op_fn,
                       sh: op_sh, res_ld: op_res_ld, dest: op_dest};

    busdp_store_seq u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .uop    (seq_uop),
        .busy   (busy),
        .done   (done),
        .mem_ma (mem_ma),
        .mem_wr (mem_wr)
    );

    // sequencer owns the datapath whenever it is running
    assign uop_sel    = busy ? seq_uop : ext_uop;
    assign res_ld_sel = uop_sel.res_ld;

    busdp_regfile #(.DW(DW)) u_rf (
        .clk      (clk),
        .rst_n    (rst_n),
        .dest     (uop_sel.dest),
        .wdata    (result_q),
        .ext_data (ext_data),
        .src_a    (uop_sel.src_a),
        .src_b    (uop_sel.src_b),
        .bus_a    (bus_a),
        .bus_b    (bus_b),
        .mar_q    (mem_addr),
        .mbr_q    (mem_wdata)
    );

    busdp_alu_shift #(.DW(DW)) u_alu (
        .opa (bus_a),
        .opb (bus_b),
        .fn  (uop_sel.fn),
        .sh  (uop_sel.sh),
        .y   (shift_y)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result_q <= '0;
        end else if (res_ld_sel) begin
            result_q <= shift_y;
        end
    end

endmodule

// File: rtl/busdp_core_chk.sv
module busdp_core_chk #(
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          busy,
    input logic          done,
    input logic          mem_ma,
    input logic          mem_wr,
    input logic          res_ld,
    input logic [DW-1:0] result_q,
    input logic [DW-1:0] mem_addr
);

    AST_WR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) mem_wr |=> !mem_wr); // R8
    AST_WR_WITH_MA: assert property (@(posedge clk) disable iff (!rst_n) mem_wr |-> mem_ma); // R8
    AST_ADDR_STEADY: assert property (@(posedge clk) disable iff (!rst_n) mem_wr |-> $stable(mem_addr)); // R8
    AST_DONE_AFTER_WR: assert property (@(posedge clk) disable iff (!rst_n) done |-> $past(mem_wr)); // R9
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> (!done && !busy)); // R9
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !res_ld |=> $stable(result_q)); // R5
    AST_START_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n) (start && !busy) |=> busy); // R7

endmodule

bind busdp_core busdp_core_chk #(.DW(DW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .mem_ma   (mem_ma),
    .mem_wr   (mem_wr),
    .res_ld   (res_ld_sel),
    .result_q (result_q),
    .mem_addr (mem_addr)
);

// File: tb/busdp_core_tb_top.sv
module busdp_core_tb_top;

    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [DW-1:0] ext_data = '0;
    logic [2:0]    op_src_a = '0, op_src_b = '0, op_fn = '0, op_dest = '0;
    logic [1:0]    op_sh = '0;
    logic          op_res_ld = 1'b0;
    logic [DW-1:0] result_q, mem_addr, mem_wdata;
    logic          mem_ma, mem_wr, busy, done;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    busdp_core #(.DW(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .ext_data(ext_data),
        .op_src_a(op_src_a), .op_src_b(op_src_b), .op_fn(op_fn),
        .op_sh(op_sh), .op_res_ld(op_res_ld), .op_dest(op_dest),
        .result_q(result_q), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ma(mem_ma), .mem_wr(mem_wr), .busy(busy), .done(done)
    );

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic clear_ops();
        op_src_a = '0; op_src_b = '0; op_fn = '0; op_sh = '0;
        op_res_ld = 1'b0; op_dest = '0;
    endtask

    task automatic step(input logic [2:0] sa, input logic [2:0] sb, input logic [2:0] fn,
                        input logic [1:0] sh, input logic ld, input logic [2:0] d);
        op_src_a = sa; op_src_b = sb; op_fn = fn; op_sh = sh; op_res_ld = ld; op_dest = d;
        @(negedge clk);
        clear_ops();
    endtask

    task automatic load(input logic [2:0] code, input logic [DW-1:0] v);
        ext_data = v;
        step(3'd3, 3'd0, 3'd0, 2'd0, 1'b1, 3'd0);
        step(3'd0, 3'd0, 3'd0, 2'd0, 1'b0, code);
    endtask

    task automatic read(input logic [2:0] code, output logic [DW-1:0] v);
        step(code, 3'd0, 3'd0, 2'd0, 1'b1, 3'd0);
        v = result_q;
    endtask

    function automatic logic [DW-1:0] shx(input logic [DW-1:0] v, input int sh);
        if (sh == 1) return {v[DW-2:0], 1'b0};
        if (sh == 2) return {1'b0, v[DW-1:1]};
        return v;
    endfunction

    function automatic logic [DW-1:0] pat(input int code);
        return DW'(16'h1011 * code + 16'h0100);
    endfunction

    task automatic run_store(input logic [DW-1:0] pc, input logic [DW-1:0] a, input logic [DW-1:0] s);
        logic [DW-1:0] v;
        load(3'd2, pc); load(3'd4, a); load(3'd5, s);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R9 busy after start", {15'd0, busy}, 16'd1);
        // R10: hostile fields during the busy window
        ext_data = 16'hDEAD; op_src_a = 3'd3; op_res_ld = 1'b1; op_dest = 3'd4; start = 1'b1;
        for (int k = 2; k <= 10; k++) begin
            @(negedge clk);
            if (k < 9) chk("R8 no early write", {15'd0, mem_wr}, 16'd0);
            if (k == 9) begin
                chk("R8 write strobe", {14'd0, mem_ma, mem_wr}, 16'd3);
                chk("R8 write address", mem_addr, s);
                chk("R8 write data", mem_wdata, a);
                chk("R9 no done during write", {15'd0, done}, 16'd0);
            end
            if (k == 10) begin
                chk("R9 done pulse", {14'd0, done, busy}, 16'd3);
                chk("R8 write single cycle", {14'd0, mem_ma, mem_wr}, 16'd0);
                clear_ops(); start = 1'b0;
            end
        end
        @(negedge clk);
        chk("R9 idle after done", {14'd0, done, busy}, 16'd0);
        chk("R7 result holds A", result_q, a);
        chk("R7 MAR is S", mem_addr, s);
        chk("R7 MBR is A", mem_wdata, a);
        read(3'd2, v); chk("R7 PC incremented", v, pc + 16'd1);
        read(3'd4, v); chk("R10 ACC untouched", v, a);
        read(3'd5, v); chk("R7 S untouched", v, s);
    endtask

    initial begin
        #1_000_000;
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] v;
        logic [DW-1:0] vals [6];
        vals = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000, 16'hFFFF, 16'hA5C3};
        repeat (3) @(negedge clk);
        chk("R1 result reset", result_q, 16'd0);
        chk("R1 MAR reset", mem_addr, 16'd0);
        chk("R1 MBR reset", mem_wdata, 16'd0);
        chk("R1 strobes reset", {12'd0, mem_ma, mem_wr, busy, done}, 16'd0);
        rst_n = 1'b1;
        @(negedge clk);
        read(3'd2, v); chk("R1 PC reset", v, 16'd0);
        read(3'd4, v); chk("R1 ACC reset", v, 16'd0);
        read(3'd5, v); chk("R1 S reset", v, 16'd0);

        // R2: source map on both buses
        load(3'd2, 16'h0F0F); load(3'd4, 16'h1234); load(3'd5, 16'hABCD);
        load(3'd6, 16'h5555); load(3'd7, 16'hAAAA);
        ext_data = 16'h3C3C;
        for (int c = 0; c < 8; c++) begin
            logic [DW-1:0] e;
            case (c)
                0: e = 16'h0000; 1: e = 16'h0001; 2: e = 16'h0F0F; 3: e = 16'h3C3C;
                4: e = 16'h1234; 5: e = 16'hABCD; 6: e = 16'h5555; default: e = 16'hAAAA;
            endcase
            step(3'(c), 3'd0, 3'd0, 2'd0, 1'b1, 3'd0);
            chk("R2 bus A source", result_q, e);
            step(3'd0, 3'(c), 3'd5, 2'd0, 1'b1, 3'd0);
            chk("R2 bus B source", result_q, e);
        end
        chk("R11 address shows MAR", mem_addr, 16'h5555);
        chk("R11 data shows MBR", mem_wdata, 16'hAAAA);

        // R3 and R4: sweep operand pairs and shift codes
        foreach (vals[i]) begin
            foreach (vals[j]) begin
                load(3'd4, vals[i]); load(3'd5, vals[j]);
                step(3'd4, 3'd5, 3'd5, 2'd0, 1'b1, 3'd0);
                chk("R3 add", result_q, vals[i] + vals[j]);
                step(3'd4, 3'd5, 3'd0, 2'd0, 1'b1, 3'd0);
                chk("R3 pass", result_q, vals[i]);
            end
            for (int sh = 0; sh < 4; sh++) begin
                ext_data = vals[i];
                step(3'd3, 3'd0, 3'd0, 2'(sh), 1'b1, 3'd0);
                chk("R4 shift", result_q, shx(vals[i], sh));
            end
        end
        ext_data = 16'hFFFF;
        for (int f = 0; f < 8; f++) begin
            if (f != 0 && f != 5) begin
                step(3'd3, 3'd1, 3'(f), 2'd0, 1'b1, 3'd0);
                chk("R3 unused function zero", result_q, 16'd0);
            end
        end

        // R6: every destination code
        for (int d = 0; d < 8; d++) begin
            load(3'd2, pat(2)); load(3'd4, pat(4)); load(3'd5, pat(5));
            load(3'd6, pat(6)); load(3'd7, pat(7));
            ext_data = 16'h7E57;
            step(3'd3, 3'd0, 3'd0, 2'd0, 1'b1, 3'd0);
            step(3'd0, 3'd0, 3'd0, 2'd0, 1'b0, 3'(d));
            read(3'd1, v); chk("R6 constant stays one", v, 16'd1);
            for (int c = 2; c < 8; c++) begin
                if (c != 3) begin
                    read(3'(c), v);
                    chk("R6 destination decode", v, (c == d) ? 16'h7E57 : pat(c));
                end
            end
        end

        // R5: capture and write-back in the same cycle
        ext_data = 16'h1111;
        step(3'd3, 3'd0, 3'd0, 2'd0, 1'b1, 3'd0);
        ext_data = 16'h2222;
        step(3'd3, 3'd0, 3'd0, 2'd0, 1'b1, 3'd4);
        chk("R5 new result captured", result_q, 16'h2222);
        step(3'd3, 3'd0, 3'd0, 2'd0, 1'b0, 3'd0);
        chk("R5 result holds", result_q, 16'h2222);
        read(3'd4, v); chk("R5 destination got old result", v, 16'h1111);

        // R7..R10: store routine
        run_store(16'h0000, 16'h1234, 16'h0456);
        run_store(16'hFFFF, 16'h8001, 16'hFFFE);
        run_store(16'h00FF, 16'h0000, 16'h7FFF);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule